// File: doc/BRIEF.md
# Parallel Port Register Block

This block gives a bus master the three classic registers of a PC-compatible parallel printer port. It maps them onto the port pins. The registers are a data register, a read-only status register and a control register, each reached through a small address/read/write bus.

Writes to the data register set the byte offered on the eight data lines. A direction bit in the control register switches those drivers off, so that an attached device can drive the lines. Reading the data register returns the level actually on the lines. Five input pins are resynchronised into the status register. Four control bits drive handshake outputs, and some of these outputs are inverted.

An interrupt can be enabled on the rising edge of the acknowledge input. The interrupt output is a level that stays high until software reads the status register.

Top module: `pport_regs`

## Requirements
- R1: After reset the data output is 0x00 and the data drivers are enabled (`pd_oe` = 1). `nstrobe_pin`, `nautofd_pin` and `nselin_pin` are high, `ninit_pin` is low and `irq` is low.
- R2: A write to offset 0 (data register) appears on `pd_out` from the clock edge that accepts it.
- R3: Control bit 5 is the direction bit. When it is 1, `pd_oe` is 0 (drivers tri-stated). When it is 0, `pd_oe` is 1. It takes effect from the edge that accepts the control write.
- R4: Offset 2 (control register) holds six bits. Bit 0 drives `nstrobe_pin` inverted, bit 1 drives `nautofd_pin` inverted, bit 2 drives `ninit_pin` directly and bit 3 drives `nselin_pin` inverted. A read returns the six bits with bits 7:6 as 0.
- R5: A read of offset 0 returns the level of `pd_in` through a two-flop synchroniser. A value present before clock edge k is returned after edge k+1.
- R6: A read of offset 1 (status register) returns the following, with the same two-edge synchroniser latency:
  - bit 7 = NOT `busy_pin`
  - bit 6 = `nack_pin`
  - bit 5 = `perror_pin`
  - bit 4 = `select_pin`
  - bit 3 = `nfault_pin`
  - bits 2:0 = 0
- R7: Writes to offset 1 or offset 3 change no state. A read of offset 3 returns 0x00.
- R8: When control bit 4 is 1, a rising edge of the synchronised `nack_pin` sets `irq`. A rise present on the pin before edge k makes `irq` high after edge k+2. A falling edge, or a rise while bit 4 is 0, sets nothing.
- R9: `irq` stays high until a read of offset 1 is accepted, and it is low after that edge. If a new enabled rise is detected in the same cycle as the read, `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the interrupt on a status read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pd_in | input | 8 | Level sensed on the data lines |
| pd_out | output | 8 | Value to drive on the data lines |
| pd_oe | output | 1 | Data line driver enable |
| busy_pin | input | 1 | Busy input |
| nack_pin | input | 1 | Acknowledge input, active low |
| perror_pin | input | 1 | Paper error input |
| select_pin | input | 1 | Select input |
| nfault_pin | input | 1 | Fault input, active low |
| nstrobe_pin | output | 1 | Strobe output, active low |
| nautofd_pin | output | 1 | Auto-feed output, active low |
| ninit_pin | output | 1 | Initialise output, active low |
| nselin_pin | output | 1 | Select-in output, active low |
| irq | output | 1 | Interrupt level |

## Verification
Register writes show on the pins and in read-back one edge after acceptance. Pin levels reach `bus_rdata` two edges after they change. An enabled acknowledge rise reaches `irq` three edges after the pin moves, and a status read drops it one edge after acceptance.

The bench drives inputs just after each rising edge and checks in the second half of the cycle. A queue-based model advances on the same edges, so every output is compared in exactly the cycle its latency puts it. Directed checks probe the cycle before each result is due as well as the cycle it arrives.

// File: rtl/pport_regs.sv
module pport_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  input  logic       busy_pin,
  input  logic       nack_pin,
  input  logic       perror_pin,
  input  logic       select_pin,
  input  logic       nfault_pin,
  output logic       nstrobe_pin,
  output logic       nautofd_pin,
  output logic       ninit_pin,
  output logic       nselin_pin,
  output logic       irq
);

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  localparam int B_STB  = 0;
  localparam int B_AFD  = 1;
  localparam int B_INIT = 2;
  localparam int B_SEL  = 3;
  localparam int B_IEN  = 4;
  localparam int B_DIR  = 5;

  logic [7:0] data_q;
  logic [5:0] ctrl_q;
  logic [7:0] pd_s1, pd_s2;
  logic [4:0] st_s1, st_s2;
  logic       nack_s3;
  logic       irq_q;

  wire nack_rise = st_s2[3] & ~nack_s3;
  wire stat_rd   = bus_rd && (bus_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DATA) data_q <= bus_wdata;
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_s1   <= '0;
      pd_s2   <= '0;
      st_s1   <= '0;
      st_s2   <= '0;
      nack_s3 <= 1'b0;
    end else begin
      pd_s1   <= pd_in;
      pd_s2   <= pd_s1;
      st_s1   <= {busy_pin, nack_pin, perror_pin, select_pin, nfault_pin};
      st_s2   <= st_s1;
      nack_s3 <= st_s2[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          irq_q <= 1'b0;
    else if (ctrl_q[B_IEN] && nack_rise) irq_q <= 1'b1;
    else if (stat_rd)                    irq_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = pd_s2;
      A_STAT:  bus_rdata = {~st_s2[4], st_s2[3:0], 3'b000};
      A_CTRL:  bus_rdata = {2'b00, ctrl_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign pd_out      = data_q;
  assign pd_oe       = ~ctrl_q[B_DIR];
  assign nstrobe_pin = ~ctrl_q[B_STB];
  assign nautofd_pin = ~ctrl_q[B_AFD];
  assign ninit_pin   =  ctrl_q[B_INIT];
  assign nselin_pin  = ~ctrl_q[B_SEL];
  assign irq         = irq_q;

  p_data_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_DATA |=> pd_out == $past(bus_wdata));

  p_dir_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_CTRL |=> pd_oe == !$past(bus_wdata[5]));

  p_strobe_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_CTRL |=> nstrobe_pin == !$past(bus_wdata[0]));

  p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == A_STAT |-> bus_rdata[2:0] == 3'b000);

  p_ignored_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr[0] |=> $stable(pd_out) && $stable(pd_oe) && $stable(nselin_pin));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(nack_rise));

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !nack_rise |=> !irq);

endmodule

// File: tb/pport_regs_tb.sv
module pport_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pd_in = '0;
  logic [7:0] pd_out;
  logic       pd_oe;
  logic       busy_pin = 0, nack_pin = 0, perror_pin = 0, select_pin = 0, nfault_pin = 0;
  logic       nstrobe_pin, nautofd_pin, ninit_pin, nselin_pin, irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  pport_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_in(pd_in), .pd_out(pd_out),
    .pd_oe(pd_oe), .busy_pin(busy_pin), .nack_pin(nack_pin), .perror_pin(perror_pin),
    .select_pin(select_pin), .nfault_pin(nfault_pin), .nstrobe_pin(nstrobe_pin),
    .nautofd_pin(nautofd_pin), .ninit_pin(ninit_pin), .nselin_pin(nselin_pin), .irq(irq));

  always #5 clk = ~clk;

  // reference model: pin history queue, newest sample at index 0
  logic [12:0] hist[$];
  logic [7:0]  m_data;
  logic [5:0]  m_ctrl;
  logic        m_irq;

  initial begin
    hist = '{13'h0, 13'h0, 13'h0};
    m_data = '0; m_ctrl = '0; m_irq = 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{13'h0, 13'h0, 13'h0};
      m_data = '0; m_ctrl = '0; m_irq = 1'b0;
    end else begin
      bit rise;
      rise = hist[1][3] && !hist[2][3];
      if (m_ctrl[4] && rise) m_irq = 1'b1;
      else if (bus_rd && bus_addr == 2'd1) m_irq = 1'b0;
      if (bus_wr && bus_addr == 2'd0) m_data = bus_wdata;
      if (bus_wr && bus_addr == 2'd2) m_ctrl = bus_wdata[5:0];
      hist.push_front({pd_in, busy_pin, nack_pin, perror_pin, select_pin, nfault_pin});
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return hist[1][12:5];
      2'd1:    return {~hist[1][4], hist[1][3:0], 3'b000};
      2'd2:    return {2'b00, m_ctrl};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model pd_out", pd_out, m_data);
      chk("R3 model pd_oe", {7'b0, pd_oe}, {7'b0, ~m_ctrl[5]});
      chk("R4 model pins", {4'b0, nstrobe_pin, nautofd_pin, ninit_pin, nselin_pin},
          {4'b0, ~m_ctrl[0], ~m_ctrl[1], m_ctrl[2], ~m_ctrl[3]});
      chk("R5/R6/R7 model rdata", bus_rdata, exp_rd(bus_addr));
      chk("R8/R9 model irq", {7'b0, irq}, {7'b0, m_irq});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_status();
    bus_addr = 2'd1; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 pd_out", pd_out, 8'h00);
    chk("R1 pd_oe", {7'b0, pd_oe}, 8'h01);
    chk("R1 pins", {4'b0, nstrobe_pin, nautofd_pin, ninit_pin, nselin_pin}, 8'h0D);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 data writes
    wr(2'd0, 8'hA5); chk("R2 data A5", pd_out, 8'hA5);
    wr(2'd0, 8'h3C); chk("R2 data 3C", pd_out, 8'h3C);
    wr(2'd0, 8'hFF); chk("R2 data FF", pd_out, 8'hFF);

    // R4 control pin mapping and read-back
    wr(2'd2, 8'h01);
    chk("R4 strobe", {4'b0, nstrobe_pin, nautofd_pin, ninit_pin, nselin_pin}, 8'h05);
    wr(2'd2, 8'h0F);
    chk("R4 all four", {4'b0, nstrobe_pin, nautofd_pin, ninit_pin, nselin_pin}, 8'h02);
    wr(2'd2, 8'h04);
    chk("R4 init only", {4'b0, nstrobe_pin, nautofd_pin, ninit_pin, nselin_pin}, 8'h0F);
    wr(2'd2, 8'hCA);
    bus_addr = 2'd2; #1;
    chk("R4 readback", bus_rdata, 8'h0A);

    // R3 direction
    wr(2'd2, 8'h20);
    chk("R3 tristate", {7'b0, pd_oe}, 8'h00);
    chk("R3 data held", pd_out, 8'hFF);
    wr(2'd2, 8'h00);
    chk("R3 drive", {7'b0, pd_oe}, 8'h01);

    // R5 data line read with sync latency
    bus_addr = 2'd0;
    pd_in = 8'h5A;
    tick(); chk("R5 one edge old", bus_rdata, 8'h00);
    tick(); chk("R5 5A", bus_rdata, 8'h5A);
    pd_in = 8'hC3;
    tick(2); chk("R5 C3", bus_rdata, 8'hC3);

    // R6 status mapping
    bus_addr = 2'd1;
    busy_pin = 1; nack_pin = 0; perror_pin = 1; select_pin = 0; nfault_pin = 1;
    tick(2); chk("R6 status 28", bus_rdata, 8'h28);
    busy_pin = 0; nack_pin = 1; perror_pin = 0; select_pin = 1; nfault_pin = 0;
    tick(); chk("R6 status one edge old", bus_rdata, 8'h28);
    tick(); chk("R6 status D0", bus_rdata, 8'hD0);
    tick(2);
    chk("R8 no irq when disabled", {7'b0, irq}, 8'h00);

    // R7 ignored writes
    wr(2'd2, 8'h0B);
    wr(2'd1, 8'hFF);
    bus_addr = 2'd2; #1;
    chk("R7 ctrl after status write", bus_rdata, 8'h0B);
    chk("R7 data after status write", pd_out, 8'hFF);
    wr(2'd3, 8'h55);
    bus_addr = 2'd2; #1;
    chk("R7 ctrl after offset3 write", bus_rdata, 8'h0B);
    chk("R7 data after offset3 write", pd_out, 8'hFF);
    bus_addr = 2'd3; #1;
    chk("R7 offset3 reads 0", bus_rdata, 8'h00);

    // R8 interrupt on enabled rise
    wr(2'd2, 8'h10);
    nack_pin = 0;
    tick(4); chk("R8 falling edge no irq", {7'b0, irq}, 8'h00);
    nack_pin = 1;
    tick(2); chk("R8 not yet", {7'b0, irq}, 8'h00);
    tick();  chk("R8 irq set", {7'b0, irq}, 8'h01);

    // R9 hold and clear
    tick(5); chk("R9 irq held", {7'b0, irq}, 8'h01);
    bus_addr = 2'd0; bus_rd = 1'b1; tick(); bus_rd = 1'b0;
    chk("R9 data read keeps irq", {7'b0, irq}, 8'h01);
    rd_status();
    chk("R9 cleared by status read", {7'b0, irq}, 8'h00);

    // R9 rise coincident with status read keeps irq
    nack_pin = 0; tick(4);
    nack_pin = 1; tick(2);
    rd_status();
    chk("R9 set wins over clear", {7'b0, irq}, 8'h01);
    rd_status();
    chk("R9 second read clears", {7'b0, irq}, 8'h00);

    // R8 disabled rise
    wr(2'd2, 8'h00);
    nack_pin = 0; tick(4);
    nack_pin = 1; tick(4);
    chk("R8 disabled rise ignored", {7'b0, irq}, 8'h00);

    tick(2);
    finish_run();
  end
endmodule